// File: doc/BRIEF.md
# Eight-Bit Register Processor Core

This block is a small multi-cycle processor with an 8-bit data path, eight general registers and a single 256-byte memory that holds both code and stack. Each instruction takes two clock cycles: a fetch cycle captures the opcode byte at the program counter together with the two bytes after it, and an execute cycle carries the instruction out. Instruction length and routing come from bit fields of the opcode, not from a lookup table. The top two bits give the number of operand bytes. Bit 5 sends the instruction to the arithmetic unit. Bit 4 means the instruction sets the program counter itself.

Register 7 doubles as the stack pointer and register 6 holds compare results. There is no separate flags register. The print instruction appears at the ports as a one-cycle strobe that carries a data byte. A program is written into memory through a load port while reset is held low. Once reset is released, the core runs until it meets a halt or an opcode it does not know.

Top module: `cpu8_core`

## Requirements
- R1: While rst_n is low, writes on the load port (ld_we, ld_addr, ld_data) store bytes into memory, and out_valid, halted and illegal read 0. After release, execution starts at address 0x00 with every register zero except register 7, which holds 0xF4.
- R2: Every instruction takes one fetch cycle and one execute cycle. For an opcode whose bit 4 is clear, the program counter advances by 1 plus opcode bits [7:6]. Operand bytes name a register through their low three bits.
- R3: Opcode 0x82 writes its second operand byte into the register named by its first operand.
- R4: Opcode 0x47 raises out_valid for exactly one cycle, with out_data equal to the named register, in the cycle after its execute cycle.
- R5: Opcodes with bit 5 set go to the arithmetic unit, with register indices in both operands. 0xA0 adds the second register into the first and 0xA2 multiplies them, keeping the low 8 bits. 0xA7 writes 0x04 (first below second), 0x02 (first above second) or 0x01 (equal) into register 6.
- R6: Opcode 0x45 decrements register 7 and then stores the named register at the new address. Opcode 0x46 loads the byte at register 7 into the named register and then increments register 7.
- R7: Opcode 0x50 decrements register 7, stores PC+2 there, and jumps to the address in the named register. Opcode 0x11 pops the top of the stack into the program counter and increments register 7.
- R8: Opcode 0x54 jumps to the address in the named register. Opcode 0x55 jumps only when bit 0 of register 6 is set, and otherwise goes to PC+2. Opcode 0x56 goes to PC+2 when register 6 equals exactly 0x01, and otherwise jumps.
- R9: Opcode 0x01 sets halted. halted stays high until reset, and after it no further out_valid pulse appears.
- R10: Any opcode not listed above, including an undefined opcode with bit 5 set, halts the core and sets illegal, which stays high until reset.
- R11: All register, stack pointer and address arithmetic wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; while low, the load port owns memory |
| ld_we | input | 1 | Program load write enable (honoured during reset only) |
| ld_addr | input | 8 | Program load address |
| ld_data | input | 8 | Program load byte |
| out_valid | output | 1 | One-cycle print strobe |
| out_data | output | 8 | Printed register value |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unknown opcode |

## Verification
The assertions assume that the load port is used only while rst_n is low. They also assume that no two print instructions can retire in back-to-back cycles, which holds because every instruction spends a fetch cycle before it executes. The stack pointer check assumes a push never names a register whose write would override register 7. The bench loads each program entirely inside reset, pushes only registers 0 to 5, and fills unused memory with 0x00 so that a stray fetch ends in an illegal halt and does not run away.

// File: rtl/cpu8_pkg.sv
// Shared constants and types for the 8-bit register processor.
// Assumes an 8-bit data path and 8-bit addresses throughout.
package cpu8_pkg;
    localparam int DW     = 8;
    localparam int AW     = 8;
    localparam int NREG   = 8;
    localparam int RIW    = $clog2(NREG);
    localparam int SP_IDX = 7;
    localparam int FL_IDX = 6;
    localparam logic [DW-1:0] SP_RESET = 8'hF4;

    localparam logic [7:0] OP_HALT  = 8'h01;
    localparam logic [7:0] OP_LOADI = 8'h82;
    localparam logic [7:0] OP_PRINT = 8'h47;
    localparam logic [7:0] OP_PUSH  = 8'h45;
    localparam logic [7:0] OP_POP   = 8'h46;
    localparam logic [7:0] OP_CALL  = 8'h50;
    localparam logic [7:0] OP_RET   = 8'h11;
    localparam logic [7:0] OP_JUMP  = 8'h54;
    localparam logic [7:0] OP_JEQ   = 8'h55;
    localparam logic [7:0] OP_JNE   = 8'h56;
    localparam logic [7:0] OP_ADD   = 8'hA0;
    localparam logic [7:0] OP_MUL   = 8'hA2;
    localparam logic [7:0] OP_CMP   = 8'hA7;

    localparam logic [DW-1:0] CMP_LT = 8'h04;
    localparam logic [DW-1:0] CMP_GT = 8'h02;
    localparam logic [DW-1:0] CMP_EQ = 8'h01;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_STOP} core_state_t;
endpackage

// File: rtl/cpu8_mem.sv
// Unified program/stack memory: one synchronous write port and NRD
// combinational read ports. Assumes no reset of contents is needed.
module cpu8_mem #(
    parameter int AW  = 8,
    parameter int DW  = 8,
    parameter int NRD = 4
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr [NRD],
    output logic [DW-1:0] rdata [NRD]
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Store a byte on the write port.
    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    // One combinational read path per port.
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = cells[raddr[g]];
    end
endmodule

// File: rtl/cpu8_regfile.sv
// General register file with two read ports, a general write port and a
// dedicated stack-pointer write port; the general port wins on a clash.
// Exposes the stack pointer and compare-result registers directly.
module cpu8_regfile #(
    parameter int NREG   = 8,
    parameter int DW     = 8,
    parameter int SP_IDX = 7,
    parameter int FL_IDX = 6,
    parameter logic [DW-1:0] SP_INIT = 8'hF4,
    localparam int RIW   = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wa_en,
    input  logic [RIW-1:0] wa_idx,
    input  logic [DW-1:0]  wa_data,
    input  logic           sp_en,
    input  logic [DW-1:0]  sp_data,
    input  logic [RIW-1:0] ra_idx,
    output logic [DW-1:0]  ra_data,
    input  logic [RIW-1:0] rb_idx,
    output logic [DW-1:0]  rb_data,
    output logic [DW-1:0]  sp_q,
    output logic [DW-1:0]  fl_q
);
    logic [DW-1:0] regs [NREG];

    // Reset values, then stack-pointer update, then general write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++)
                regs[i] <= (i == SP_IDX) ? SP_INIT : '0;
        end else begin
            if (sp_en) regs[SP_IDX] <= sp_data;
            if (wa_en) regs[wa_idx] <= wa_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];
    assign sp_q    = regs[SP_IDX];
    assign fl_q    = regs[FL_IDX];
endmodule

// File: rtl/cpu8_alu.sv
// Arithmetic unit for opcodes with bit 5 set. Reports whether the opcode
// is known and whether the result targets the compare register.
module cpu8_alu
    import cpu8_pkg::*;
(
    input  logic [7:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res,
    output logic          to_flags,
    output logic          known
);
    logic [2*DW-1:0] prod;

    assign prod = a * b;

    // Select the result for the decoded operation.
    always_comb begin
        res      = '0;
        to_flags = 1'b0;
        known    = 1'b1;
        case (op)
            OP_ADD: res = a + b;
            OP_MUL: res = prod[DW-1:0];
            OP_CMP: begin
                to_flags = 1'b1;
                if (a < b)      res = CMP_LT;
                else if (a > b) res = CMP_GT;
                else            res = CMP_EQ;
            end
            default: known = 1'b0;
        endcase
    end
endmodule

// File: rtl/cpu8_core.sv
// Two-cycle fetch/execute processor core. Memory is written from the load
// port while rst_n is low and by the core otherwise. Assumes the loader
// only drives ld_we during reset.
module cpu8_core
    import cpu8_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data,
    output logic          halted,
    output logic          illegal
);
    localparam int NRD = 4;

    core_state_t   state_q;
    logic [AW-1:0] pc_q;
    logic [7:0]    ir_q;
    logic [DW-1:0] opa_q, opb_q;
    logic          in_exec;

    logic [AW-1:0] rd_addr [NRD];
    logic [DW-1:0] rd_data [NRD];
    logic [DW-1:0] ra, rb, sp_q, fl_q;
    logic [DW-1:0] alu_res;
    logic          alu_fl, alu_ok;

    logic          wa_en, sp_en, mw_en, prn_c, stop_c, bad_c;
    logic [RIW-1:0] wa_idx;
    logic [DW-1:0] wa_data, sp_data, mw_data;
    logic [AW-1:0] mw_addr, pc_n, pc_seq, pc_skip;
    logic          go;

    assign in_exec = (state_q == ST_EXEC);
    assign pc_seq  = pc_q + 8'd1 + {6'd0, ir_q[7:6]};
    assign pc_skip = pc_q + 8'd2;

    // Read ports: opcode, two operands, top of stack.
    always_comb begin
        rd_addr[0] = pc_q;
        rd_addr[1] = pc_q + 8'd1;
        rd_addr[2] = pc_q + 8'd2;
        rd_addr[3] = sp_q;
    end

    cpu8_mem #(.AW(AW), .DW(DW), .NRD(NRD)) u_mem (
        .clk   (clk),
        .we    (rst_n ? mw_en : ld_we),
        .waddr (rst_n ? mw_addr : ld_addr),
        .wdata (rst_n ? mw_data : ld_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    cpu8_regfile #(
        .NREG(NREG), .DW(DW), .SP_IDX(SP_IDX), .FL_IDX(FL_IDX), .SP_INIT(SP_RESET)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wa_en   (wa_en),
        .wa_idx  (wa_idx),
        .wa_data (wa_data),
        .sp_en   (sp_en),
        .sp_data (sp_data),
        .ra_idx  (opa_q[RIW-1:0]),
        .ra_data (ra),
        .rb_idx  (opb_q[RIW-1:0]),
        .rb_data (rb),
        .sp_q    (sp_q),
        .fl_q    (fl_q)
    );

    cpu8_alu u_alu (
        .op       (ir_q),
        .a        (ra),
        .b        (rb),
        .res      (alu_res),
        .to_flags (alu_fl),
        .known    (alu_ok)
    );

    // Decode the latched opcode into register, memory and PC effects.
    always_comb begin
        pc_n    = pc_seq;
        wa_en   = 1'b0;
        wa_idx  = opa_q[RIW-1:0];
        wa_data = opb_q;
        sp_en   = 1'b0;
        sp_data = sp_q;
        mw_en   = 1'b0;
        mw_addr = sp_q - 8'd1;
        mw_data = ra;
        prn_c   = 1'b0;
        stop_c  = 1'b0;
        bad_c   = 1'b0;
        if (ir_q[5]) begin
            if (alu_ok) begin
                wa_en   = 1'b1;
                wa_idx  = alu_fl ? RIW'(FL_IDX) : opa_q[RIW-1:0];
                wa_data = alu_res;
            end else begin
                stop_c = 1'b1;
                bad_c  = 1'b1;
            end
        end else begin
            case (ir_q)
                OP_LOADI: wa_en = 1'b1;
                OP_PRINT: prn_c = 1'b1;
                OP_PUSH: begin
                    sp_en   = 1'b1;
                    sp_data = sp_q - 8'd1;
                    mw_en   = 1'b1;
                end
                OP_POP: begin
                    wa_en   = 1'b1;
                    wa_data = rd_data[3];
                    sp_en   = 1'b1;
                    sp_data = sp_q + 8'd1;
                end
                OP_CALL: begin
                    sp_en   = 1'b1;
                    sp_data = sp_q - 8'd1;
                    mw_en   = 1'b1;
                    mw_data = pc_skip;
                    pc_n    = ra;
                end
                OP_RET: begin
                    pc_n    = rd_data[3];
                    sp_en   = 1'b1;
                    sp_data = sp_q + 8'd1;
                end
                OP_JUMP: pc_n = ra;
                OP_JEQ:  pc_n = fl_q[0] ? ra : pc_skip;
                OP_JNE:  pc_n = (fl_q == CMP_EQ) ? pc_skip : ra;
                OP_HALT: stop_c = 1'b1;
                default: begin
                    stop_c = 1'b1;
                    bad_c  = 1'b1;
                end
            endcase
        end
        go = in_exec && !stop_c;
        wa_en = wa_en && go;
        sp_en = sp_en && go;
        mw_en = mw_en && go;
    end

    // Sequencer: fetch latches, execute commits, stop holds until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_FETCH;
            pc_q      <= '0;
            ir_q      <= '0;
            opa_q     <= '0;
            opb_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            halted    <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (state_q)
                ST_FETCH: begin
                    ir_q    <= rd_data[0];
                    opa_q   <= rd_data[1];
                    opb_q   <= rd_data[2];
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (stop_c) begin
                        state_q <= ST_STOP;
                        halted  <= 1'b1;
                        illegal <= bad_c;
                    end else begin
                        pc_q    <= pc_n;
                        state_q <= ST_FETCH;
                        if (prn_c) begin
                            out_valid <= 1'b1;
                            out_data  <= ra;
                        end
                    end
                end
                default: state_q <= ST_STOP;
            endcase
        end
    end
endmodule

// File: rtl/cpu8_core_chk.sv
// Property checker for cpu8_core, attached by bind below.
// Assumes pushes never name register 7.
module cpu8_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       out_valid,
    input logic       halted,
    input logic       illegal,
    input logic       in_exec,
    input logic [7:0] ir,
    input logic [7:0] pc,
    input logic [7:0] sp
);
    AST_PRINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R4

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !out_valid); // R9

    AST_ILLEGAL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> halted); // R10

    AST_PUSH_SP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir == 8'h45) |=> sp == 8'($past(sp) - 8'd1)); // R6

    AST_POP_SP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && ir == 8'h46) |=> sp == 8'($past(sp) + 8'd1)); // R6

    AST_PC_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && (ir == 8'h82 || ir == 8'h47 || ir == 8'h45 || ir == 8'h46))
        |=> pc == 8'($past(pc) + 8'd1 + {6'd0, $past(ir[7:6])})); // R2
endmodule

bind cpu8_core cpu8_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .halted    (halted),
    .illegal   (illegal),
    .in_exec   (in_exec),
    .ir        (ir_q),
    .pc        (pc_q),
    .sp        (sp_q)
);

// File: tb/cpu8_core_bench.sv
// Directed bench: each task builds a program, runs it and checks outputs.
module cpu8_core_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_we = 1'b0;
    logic [7:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       halted;
    logic       illegal;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int run_cycles = 0;
    logic [7:0] prog [256];
    int wp = 0;
    logic [7:0] outq [16];
    int out_n = 0;

    always #4 clk = ~clk;

    cpu8_core u_cpu8_core (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .out_valid(out_valid), .out_data(out_data),
        .halted(halted), .illegal(illegal)
    );

    // Capture printed values away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) out_n = 0;
        else if (out_valid && out_n < 16) begin
            outq[out_n] = out_data;
            out_n = out_n + 1;
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < 256; i++) prog[i] = 8'h00;
        wp = 0;
    endtask

    task automatic at(input int a);
        wp = a;
    endtask

    task automatic b(input logic [7:0] v);
        prog[wp] = v;
        wp = wp + 1;
    endtask

    // Load under reset, release, run until halted.
    task automatic run_prog();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            ld_we = 1'b1;
            ld_addr = 8'(i);
            ld_data = prog[i];
            @(negedge clk);
        end
        ld_we = 1'b0;
        @(negedge clk);
        chk("R1 reset out_valid", {31'd0, out_valid}, 0);
        chk("R1 reset halted", {31'd0, halted}, 0);
        chk("R1 reset illegal", {31'd0, illegal}, 0);
        rst_n = 1'b1;
        run_cycles = 0;
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            run_cycles = run_cycles + 1;
            if (halted) break;
        end
    endtask

    task automatic test_loadi_print();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h08);
        b(8'h82); b(8'h03); b(8'hFF);
        b(8'h47); b(8'h00);
        b(8'h47); b(8'h03);
        b(8'h01);
        run_prog();
        chk("R2 two cycles per instruction", run_cycles, 10);
        chk("R4 print count", out_n, 2);
        chk("R3 loadi r0", outq[0], 8'h08);
        chk("R3 loadi r3", outq[1], 8'hFF);
        chk("R9 halted", {31'd0, halted}, 1);
        chk("R9 not illegal", {31'd0, illegal}, 0);
    endtask

    task automatic test_alu();
        clear_prog();
        b(8'h82); b(8'h00); b(8'd20);
        b(8'h82); b(8'h01); b(8'd20);
        b(8'hA2); b(8'h00); b(8'h01);
        b(8'h47); b(8'h00);
        b(8'h82); b(8'h02); b(8'hF0);
        b(8'h82); b(8'h03); b(8'h20);
        b(8'hA0); b(8'h02); b(8'h03);
        b(8'h47); b(8'h02);
        b(8'hA7); b(8'h02); b(8'h03);
        b(8'h47); b(8'h06);
        b(8'hA7); b(8'h03); b(8'h02);
        b(8'h47); b(8'h06);
        b(8'hA7); b(8'h03); b(8'h03);
        b(8'h47); b(8'h06);
        b(8'h01);
        run_prog();
        chk("R5 alu print count", out_n, 5);
        chk("R11 R5 mul wraps 400", outq[0], 8'd144);
        chk("R11 R5 add wraps", outq[1], 8'h10);
        chk("R5 cmp less", outq[2], 8'h04);
        chk("R5 cmp greater", outq[3], 8'h02);
        chk("R5 cmp equal", outq[4], 8'h01);
    endtask

    task automatic test_stack();
        clear_prog();
        b(8'h47); b(8'h05);
        b(8'h47); b(8'h07);
        b(8'h82); b(8'h00); b(8'h55);
        b(8'h45); b(8'h00);
        b(8'h47); b(8'h07);
        b(8'h82); b(8'h00); b(8'h00);
        b(8'h46); b(8'h01);
        b(8'h47); b(8'h01);
        b(8'h47); b(8'h07);
        b(8'h01);
        run_prog();
        chk("R6 stack print count", out_n, 5);
        chk("R1 untouched register zero", outq[0], 8'h00);
        chk("R1 stack pointer reset", outq[1], 8'hF4);
        chk("R6 push decrements", outq[2], 8'hF3);
        chk("R6 pop value", outq[3], 8'h55);
        chk("R6 pop increments", outq[4], 8'hF4);
    endtask

    task automatic test_call_ret();
        clear_prog();
        b(8'h82); b(8'h01); b(8'h20);
        b(8'h50); b(8'h01);
        b(8'h47); b(8'h02);
        b(8'h01);
        at(8'h20);
        b(8'h82); b(8'h02); b(8'h77);
        b(8'h47); b(8'h07);
        b(8'h11);
        run_prog();
        chk("R7 call print count", out_n, 2);
        chk("R7 call pushes", outq[0], 8'hF3);
        chk("R7 return path", outq[1], 8'h77);
        chk("R7 clean halt", {31'd0, illegal}, 0);
    endtask

    task automatic test_jumps();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h05);
        b(8'h82); b(8'h01); b(8'h05);
        b(8'hA7); b(8'h00); b(8'h01);
        b(8'h82); b(8'h04); b(8'h20);
        b(8'h55); b(8'h04);
        b(8'h47); b(8'h00);
        b(8'h01);
        at(8'h20);
        b(8'h82); b(8'h05); b(8'hAA);
        b(8'h56); b(8'h04);
        b(8'h47); b(8'h05);
        b(8'hA7); b(8'h00); b(8'h02);
        b(8'h82); b(8'h04); b(8'h40);
        b(8'h55); b(8'h04);
        b(8'h56); b(8'h04);
        b(8'h01);
        at(8'h40);
        b(8'h82); b(8'h05); b(8'hBB);
        b(8'h82); b(8'h04); b(8'h50);
        b(8'h54); b(8'h04);
        b(8'h01);
        at(8'h50);
        b(8'h47); b(8'h05);
        b(8'h01);
        run_prog();
        chk("R8 jump print count", out_n, 2);
        chk("R8 jeq taken, jne skipped", outq[0], 8'hAA);
        chk("R8 jeq skipped, jne taken, jmp", outq[1], 8'hBB);
        chk("R8 clean halt", {31'd0, illegal}, 0);
    endtask

    task automatic test_illegal();
        clear_prog();
        b(8'h82); b(8'h00); b(8'h01);
        b(8'h47); b(8'h00);
        b(8'h03);
        b(8'h47); b(8'h00);
        run_prog();
        chk("R10 stop cycle", run_cycles, 6);
        chk("R10 illegal flag", {31'd0, illegal}, 1);
        chk("R10 halted", {31'd0, halted}, 1);
        for (int k = 0; k < 20; k++) @(negedge clk);
        chk("R9 halt holds", {31'd0, halted}, 1);
        chk("R9 no print after halt", out_n, 1);
        clear_prog();
        b(8'hA5); b(8'h00); b(8'h00);
        run_prog();
        chk("R10 undefined alu opcode", {31'd0, illegal}, 1);
        chk("R10 undefined alu halts", {31'd0, halted}, 1);
    endtask

    initial begin
        test_loadi_print();
        test_alu();
        test_stack();
        test_call_ret();
        test_jumps();
        test_illegal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule